// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single column command into the stream of column addresses for one burst on a synchronous DRAM, presenting one 9-bit column per clock. The command gives a starting column, a length code and an ordering bit. Fixed-length bursts keep the column inside an aligned window whose size is the burst length. In sequential order the column steps upward and wraps inside that window. In interleaved order each column is the start column XORed with the beat index. A full-page burst walks all 512 columns in ascending order, wrapping from 511 to 0, and continues until something ends it.

A burst ends at its final beat, on a stop request, or when a new command arrives. A new command may be given on any clock, including the clock of the final beat, so bursts can follow back to back with no gap. The controller is a three-state machine. ST_IDLE outputs nothing. ST_FIXED runs a burst of 1, 2, 4 or 8 beats. ST_PAGE runs a full-page burst. The transitions are:

- load: from any state to ST_FIXED or ST_PAGE on start.
- finish: ST_FIXED to ST_IDLE after the final beat.
- halt: ST_FIXED or ST_PAGE to ST_IDLE on stop.
- advance: stay in ST_FIXED or ST_PAGE and step the beat.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after it is released, col_valid and col_last are 0 until the first start.
- R2: A start sampled at a clock edge makes col_valid 1 with col equal to start_col in the following cycle. A start is accepted in every state and abandons any burst in progress.
- R3: len_code 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Every len_code value of 4 or above selects a full-page burst.
- R4: In a sequential fixed-length burst of L beats, beat n has low log2(L) bits equal to (start_col + n) mod L. The upper bits stay equal to those of start_col.
- R5: In an interleaved fixed-length burst (ileave = 1), beat n is start_col XOR n.
- R6: col_last is 1 exactly on the final beat of a fixed-length burst. col_valid falls in the next cycle unless a start was sampled on that beat.
- R7: A full-page burst issues (start_col + n) mod 512, ignores ileave, never raises col_last, and keeps running past 512 beats until a stop or a start.
- R8: A stop sampled during a burst of any length, with no start, makes col_valid 0 in the next cycle.
- R9: A start and a stop sampled together act as a start.
- R10: A stop sampled while idle has no effect; col_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | New column command |
| start_col | input | 9 | Starting column of the command |
| len_code | input | 3 | Burst length code (R3) |
| ileave | input | 1 | 1 selects interleaved order for fixed-length bursts |
| stop | input | 1 | Burst stop request |
| col | output | 9 | Current column address |
| col_valid | output | 1 | col carries a beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench starts 8-beat bursts at unaligned columns such as 13. A design that carried the increment into the upper bits would leave the 8-column window instead of wrapping back to 8. Interleaved bursts from odd starts separate the XOR ordering from addition, and a full-page run longer than 512 beats exposes a design that ends, raises col_last, or stops wrapping at 511. Stops, starts on the final beat, start and stop together, stop while idle, and start on every clock would show up as a lost or extra beat, a burst that was never truncated, or col_valid rising with no command.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W    = 9,
    parameter int CODE_W   = 3,
    parameter int MAX_LOG2 = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [COL_W-1:0]  win_mask,
    output logic              full_page
);
    // Codes above the largest fixed exponent select a whole row.
    assign full_page = (32'(code) > 32'(MAX_LOG2));

    // Bit i of the window mask is set when the burst spans more than 2**i columns.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign win_mask[i] = full_page | (32'(code) > 32'(i));
    end
endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] win_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    assign sum     = base + beat;
    assign seq_col = (base & ~win_mask) | (sum & win_mask);
    assign ilv_col = base ^ (beat & win_mask);
    assign col     = ilv ? ilv_col : seq_col;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcg_pkg::*;
#(
    parameter int COL_W    = 9,
    parameter int CODE_W   = 3,
    parameter int MAX_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] len_code,
    input  logic              ileave,
    input  logic              stop,
    output logic [COL_W-1:0]  col,
    output logic              col_valid,
    output logic              col_last
);
    localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);

    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             ilv_q;
    logic             load, adv;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             final_beat;

    bcg_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2)) u_dec (
        .code      (len_code),
        .win_mask  (dec_mask),
        .full_page (dec_page)
    );

    bcg_col_calc #(.COL_W(COL_W)) u_calc (
        .base     (base_q),
        .beat     (beat_q),
        .win_mask (mask_q),
        .ilv      (ilv_q),
        .col      (col)
    );

    assign final_beat = (beat_q == mask_q);

    // Next state and step control
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) load = 1'b1;
            end
            ST_FIXED: begin
                if (start)                   load = 1'b1;
                else if (stop || final_beat) state_d = ST_IDLE;
                else                         adv = 1'b1;
            end
            ST_PAGE: begin
                if (start)     load = 1'b1;
                else if (stop) state_d = ST_IDLE;
                else           adv = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
        if (load) state_d = dec_page ? ST_PAGE : ST_FIXED;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
        end else if (load) begin
            base_q <= start_col;
            beat_q <= '0;
            mask_q <= dec_mask;
            ilv_q  <= ileave & ~dec_page;
        end else if (adv) begin
            beat_q <= beat_q + BEAT_ONE;
        end
    end

    // Outputs
    always_comb begin
        col_valid = 1'b0;
        col_last  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FIXED: begin
                col_valid = 1'b1;
                col_last  = final_beat;
            end
            ST_PAGE:  col_valid = 1'b1;
            default:  ;
        endcase
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid && !start |=> !col_valid);

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && col == $past(start_col));

    assert_window_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !start |=> !col_valid || ((col ^ $past(col)) & ~mask_q) == '0);

    assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && !start |=> !col_valid);

    assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !col_last && &mask_q && !ilv_q && !start && !stop
        |=> col_valid && !col_last && col == $past(col) + BEAT_ONE);

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !start |=> !col_valid);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       ileave = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] col;
    logic       col_valid, col_last;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit m_act = 0;
    bit m_page = 0;
    bit m_ilv = 0;
    int m_base = 0;
    int m_n = 0;
    int m_len = 1;

    always #2.5 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .ileave(ileave), .stop(stop),
        .col(col), .col_valid(col_valid), .col_last(col_last)
    );

    function automatic int exp_col();
        if (m_page)     return (m_base + m_n) % 512;
        else if (m_ilv) return m_base ^ m_n;
        else            return (m_base & ~(m_len - 1)) | ((m_base + m_n) & (m_len - 1));
    endfunction

    task automatic compare(input string tag);
        bit e_last;
        e_last = m_act && !m_page && (m_n == m_len - 1);
        n_checks++;
        if (col_valid !== m_act || col_last !== e_last ||
            (m_act && int'(col) != exp_col())) begin
            n_fail++;
            $display("FAIL %s: valid=%0b last=%0b col=%0d expected valid=%0b last=%0b col=%0d",
                     tag, col_valid, col_last, col, m_act, e_last, m_act ? exp_col() : 0);
        end
    endtask

    // compare current outputs, drive inputs, advance model one edge
    task automatic step(input string tag, input bit s, input int sc, input int lc,
                        input bit il, input bit sp);
        @(negedge clk);
        compare(tag);
        start = s; start_col = 9'(sc); len_code = 3'(lc); ileave = il; stop = sp;
        if (s) begin
            m_act = 1; m_base = sc; m_n = 0;
            m_page = (lc >= 4); m_len = m_page ? 512 : (1 << lc);
            m_ilv = il && !m_page;
        end else if (m_act) begin
            if (sp) m_act = 0;
            else if (!m_page && m_n == m_len - 1) m_act = 0;
            else m_n = (m_n + 1) % 512;
        end
        @(posedge clk);
    endtask

    task automatic idle(input string tag, input int k);
        for (int i = 0; i < k; i++) step(tag, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        idle("R1 after reset", 3);
        // R2 R3 R4: sequential lengths, unaligned starts
        step("R2 R3 R4 seq8", 1, 13, 3, 0, 0); idle("R4 seq8 wrap R6", 10);
        step("R3 R4 seq4", 1, 7, 2, 0, 0);   idle("R4 seq4 R6", 6);
        step("R3 R4 seq2", 1, 5, 1, 0, 0);   idle("R4 seq2 R6", 4);
        step("R3 R6 len1", 1, 300, 0, 1, 0); idle("R6 len1", 3);
        // R5 interleaved
        step("R5 ilv8", 1, 13, 3, 1, 0);     idle("R5 ilv8 R6", 10);
        step("R5 ilv4", 1, 6, 2, 1, 0);      idle("R5 ilv4", 6);
        step("R5 ilv2", 1, 255, 1, 1, 0);    idle("R5 ilv2", 4);
        // R7 full page, ileave ignored, runs past 512 beats
        step("R7 page", 1, 500, 7, 1, 0);    idle("R7 page wrap", 530);
        step("R8 page stop", 0, 0, 0, 0, 1); idle("R8 after page stop", 3);
        // R3 codes 4 and 5 also full page
        step("R3 code4", 1, 3, 4, 0, 0);     idle("R3 code4 run", 12);
        step("R3 code5", 1, 100, 5, 0, 0);   idle("R3 code5 run", 5);
        step("R8 stop", 0, 0, 0, 0, 1);      idle("R8 idle", 2);
        // R8 stop mid fixed burst
        step("R8 seq8", 1, 40, 3, 0, 0);     idle("R8 seq8 run", 3);
        step("R8 stop8", 0, 0, 0, 0, 1);     idle("R8 after stop8", 3);
        // R2 start mid burst truncates
        step("R2 first", 1, 16, 3, 0, 0);    idle("R2 run", 2);
        step("R2 truncate", 1, 77, 2, 1, 0); idle("R2 second", 6);
        // R2 start on the final beat: no gap
        step("R6 chain a", 1, 20, 1, 0, 0);  idle("R6 chain", 1);
        step("R6 chain b", 1, 9, 1, 0, 0);   idle("R6 chain end", 4);
        // R9 start with stop
        step("R9 go", 1, 50, 3, 0, 0);       idle("R9 run", 2);
        step("R9 both", 1, 200, 2, 0, 1);    idle("R9 after", 6);
        // R10 stop while idle
        step("R10 stop idle", 0, 0, 0, 0, 1);
        step("R10 stop idle2", 0, 0, 0, 0, 1); idle("R10 still idle", 3);
        // R2 start every clock
        for (int i = 0; i < 12; i++) step("R2 every clock", 1, i * 37, i % 6, i[0], 0);
        idle("R2 drain", 10);
        @(negedge clk);
        compare("R1 final idle");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule